// File: doc/BRIEF.md
# Two-Stage Memory Attribute Combiner

This block takes the memory attributes produced by a guest translation stage and by a hypervisor translation stage and turns them into the single effective attribute set for the access. The set has three parts: a memory type code, a read-only flag, and an indication of which stage, if any, reports a fault. By default it keeps the more restrictive type of the two stages. When the stage-two override control is set, the stage-two type replaces the stage-one type. It also supplies the fixed attributes used when translation is switched off.

Each request is qualified by `in_valid`. The combined result appears, registered, exactly one cycle later with `out_valid`. Between results the outputs hold their last value. A build parameter selects whether the override control is implemented at all.

Top module: `mattr_combine`

## Requirements
- R1: `out_valid` is high exactly one cycle after a cycle with `in_valid` high and is low otherwise. While `out_valid` is low, `eff_type`, `eff_ro` and `fault_stage` keep their previous values.
- R2: During and after reset, until the first result, `out_valid`=0, `eff_type`=000, `eff_ro`=1 and `fault_stage`=00.
- R3: Type codes are as follows: 000 device with no gathering, no reordering and no early acknowledge; 001 device with no gathering, no reordering and early acknowledge; 002-style code 010 device with no gathering, reordering and early acknowledge; 011 device allowing gathering, reordering and early acknowledge; 100 normal non-cacheable; 101 normal cacheable. When both stages are active and the override is clear, the result is the numerically lower, more restrictive code of the two.
- R4: When both stages are active and `fwb`=1, `eff_type` equals the stage-two code, whatever the stage-one code is.
- R5: When stage two is inactive, the result equals the stage-one result. In that case `fwb`, `s2_type`, `s2_ro` and `s2_fault` have no effect.
- R6: Stage one is active only when `xlat_en`=1 and `s1_en`=1, and stage two only when `xlat_en`=1 and `s2_en`=1. When stage one is inactive, its contribution is type 000 for a data access (`is_fetch`=0) or 101 for a fetch (`is_fetch`=1), writable (read-only 0), and never a fault.
- R7: `eff_ro` is 1 when any active stage marks the access read-only.
- R8: `fault_stage` is 01 when stage one is active and faults; otherwise it is 10 when stage two is active and faults; otherwise it is 00. The value 11 never appears.
- R9: Reserved type codes 110 and 111 from an active stage are treated as 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request qualifier |
| xlat_en | input | 1 | Global translation enable |
| s1_en | input | 1 | Stage-one enable |
| s2_en | input | 1 | Stage-two enable |
| fwb | input | 1 | Stage-two override of type |
| is_fetch | input | 1 | Access is an instruction fetch |
| s1_type | input | 3 | Stage-one type code |
| s1_ro | input | 1 | Stage-one read-only flag |
| s1_fault | input | 1 | Stage-one fault detected |
| s2_type | input | 3 | Stage-two type code |
| s2_ro | input | 1 | Stage-two read-only flag |
| s2_fault | input | 1 | Stage-two fault detected |
| out_valid | output | 1 | Result qualifier |
| eff_type | output | 3 | Effective type code |
| eff_ro | output | 1 | Effective read-only flag |
| fault_stage | output | 2 | 00 none, 01 stage one, 10 stage two |

## Verification
The assertions check the following on every cycle: the one-cycle valid timing and the holding of outputs, that stage-one faults win, that 11 is never reported, that a stage-two read-only flag always carries through, that a merged type never exceeds the stage-two code, and that data accesses get the strict default with both stages off. Only the bench's scenarios show that the merge picks the exact minimum over every code pair, including the reserved codes. The same holds for the override replacing the type, for stage-two inputs being ignored when that stage is off, for the fetch default, and for the reset values.

// File: rtl/mattr_pkg.sv
package mattr_pkg;

   localparam int unsigned CODE_MAX = 5;

   typedef enum logic [1:0] {
      FS_NONE = 2'b00,
      FS_ONE  = 2'b01,
      FS_TWO  = 2'b10
   } fstage_e;

endpackage

// File: rtl/mattr_s1_resolve.sv
module mattr_s1_resolve #(
   parameter int unsigned TYPE_W = 3
) (
   input  logic              s1_on,
   input  logic              is_fetch,
   input  logic [TYPE_W-1:0] s1_type,
   input  logic              s1_ro,
   input  logic              s1_fault,
   output logic [TYPE_W-1:0] r_type,
   output logic              r_ro,
   output logic              r_fault
);
   import mattr_pkg::*;

   localparam logic [TYPE_W-1:0] STRICT = '0;
   localparam logic [TYPE_W-1:0] TOPC   = TYPE_W'(CODE_MAX);

   // Stage off: strict device for data, cacheable normal for fetch, full access.
   always_comb begin
      if (s1_on) begin
         r_type  = (s1_type > TOPC) ? STRICT : s1_type;
         r_ro    = s1_ro;
         r_fault = s1_fault;
      end else begin
         r_type  = is_fetch ? TOPC : STRICT;
         r_ro    = 1'b0;
         r_fault = 1'b0;
      end
   end
endmodule

// File: rtl/mattr_merge.sv
module mattr_merge #(
   parameter int unsigned TYPE_W   = 3,
   parameter bit          FWB_IMPL = 1'b1
) (
   input  logic              s2_on,
   input  logic              fwb,
   input  logic [TYPE_W-1:0] t1,
   input  logic              ro1,
   input  logic [TYPE_W-1:0] t2,
   input  logic              ro2,
   output logic [TYPE_W-1:0] m_type,
   output logic              m_ro
);
   import mattr_pkg::*;

   localparam logic [TYPE_W-1:0] TOPC = TYPE_W'(CODE_MAX);

   logic [TYPE_W-1:0] t2_legal;
   logic [TYPE_W-1:0] t_min;
   logic              take_s2;

   assign t2_legal = (t2 > TOPC) ? '0 : t2;
   assign t_min    = (t1 < t2_legal) ? t1 : t2_legal;

   generate
      if (FWB_IMPL) begin : g_fwb
         assign take_s2 = fwb;
      end else begin : g_nofwb
         logic unused_fwb;
         assign unused_fwb = fwb;
         assign take_s2    = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!s2_on) begin
         m_type = t1;
         m_ro   = ro1;
      end else begin
         m_type = take_s2 ? t2_legal : t_min;
         m_ro   = ro1 | ro2;
      end
   end
endmodule

// File: rtl/mattr_fault_prio.sv
module mattr_fault_prio (
   input  logic                f1,
   input  logic                f2,
   output mattr_pkg::fstage_e  fs
);
   import mattr_pkg::*;

   always_comb begin
      if (f1)      fs = FS_ONE;
      else if (f2) fs = FS_TWO;
      else         fs = FS_NONE;
   end
endmodule

// File: rtl/mattr_combine.sv
module mattr_combine #(
   parameter int unsigned TYPE_W   = 3,
   parameter bit          FWB_IMPL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              xlat_en,
   input  logic              s1_en,
   input  logic              s2_en,
   input  logic              fwb,
   input  logic              is_fetch,
   input  logic [TYPE_W-1:0] s1_type,
   input  logic              s1_ro,
   input  logic              s1_fault,
   input  logic [TYPE_W-1:0] s2_type,
   input  logic              s2_ro,
   input  logic              s2_fault,
   output logic              out_valid,
   output logic [TYPE_W-1:0] eff_type,
   output logic              eff_ro,
   output logic [1:0]        fault_stage
);
   import mattr_pkg::*;

   generate
      if (TYPE_W < 3) begin : g_bad_width
         $error("mattr_combine: TYPE_W must hold the six type codes");
      end
   endgenerate

   logic              s1_on, s2_on;
   logic [TYPE_W-1:0] t1_r;
   logic              ro1_r, f1_r;
   logic [TYPE_W-1:0] m_type;
   logic              m_ro;
   fstage_e           fs_c;

   assign s1_on = xlat_en & s1_en;
   assign s2_on = xlat_en & s2_en;

   mattr_s1_resolve #(.TYPE_W(TYPE_W)) u_s1 (
      .s1_on    (s1_on),
      .is_fetch (is_fetch),
      .s1_type  (s1_type),
      .s1_ro    (s1_ro),
      .s1_fault (s1_fault),
      .r_type   (t1_r),
      .r_ro     (ro1_r),
      .r_fault  (f1_r)
   );

   mattr_merge #(.TYPE_W(TYPE_W), .FWB_IMPL(FWB_IMPL)) u_merge (
      .s2_on  (s2_on),
      .fwb    (fwb),
      .t1     (t1_r),
      .ro1    (ro1_r),
      .t2     (s2_type),
      .ro2    (s2_ro),
      .m_type (m_type),
      .m_ro   (m_ro)
   );

   mattr_fault_prio u_prio (
      .f1 (f1_r),
      .f2 (s2_on & s2_fault),
      .fs (fs_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         eff_type    <= '0;
         eff_ro      <= 1'b1;
         fault_stage <= FS_NONE;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            eff_type    <= m_type;
            eff_ro      <= m_ro;
            fault_stage <= fs_c;
         end
      end
   end

   assert_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(eff_type) && $stable(eff_ro) && $stable(fault_stage));
   assert_merge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && s1_on && s2_on && !fwb && ($past(s2_type) <= TYPE_W'(CODE_MAX)) |=>
      eff_type <= $past(s2_type));
   assert_s1off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !s1_on && !s2_on && !is_fetch |=> eff_type == '0 && !eff_ro);
   assert_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && s2_on && s2_ro |=> eff_ro);
   assert_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && s1_on && s1_fault |=> fault_stage == 2'b01);
   assert_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_stage != 2'b11);
endmodule

// File: tb/mattr_combine_test.sv
module mattr_combine_test;

   typedef struct packed {
      logic [2:0] t;
      logic       ro;
      logic [1:0] fs;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       xlat_en = 1'b0, s1_en = 1'b0, s2_en = 1'b0, fwb = 1'b0, is_fetch = 1'b0;
   logic [2:0] s1_type = '0, s2_type = '0;
   logic       s1_ro = 1'b0, s1_fault = 1'b0, s2_ro = 1'b0, s2_fault = 1'b0;
   logic       out_valid;
   logic [2:0] eff_type;
   logic       eff_ro;
   logic [1:0] fault_stage;

   int   checks = 0;
   int   fails = 0;
   bit   done = 1'b0;
   exp_t exp_q[$];
   string tag_q[$];

   always #5 clk = ~clk;

   mattr_combine uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .xlat_en(xlat_en),
      .s1_en(s1_en), .s2_en(s2_en), .fwb(fwb), .is_fetch(is_fetch),
      .s1_type(s1_type), .s1_ro(s1_ro), .s1_fault(s1_fault),
      .s2_type(s2_type), .s2_ro(s2_ro), .s2_fault(s2_fault),
      .out_valid(out_valid), .eff_type(eff_type), .eff_ro(eff_ro),
      .fault_stage(fault_stage)
   );

   function automatic logic [2:0] legal(input logic [2:0] c);
      return (c > 3'd5) ? 3'd0 : c;
   endfunction

   function automatic exp_t predict(input logic ge, s1e, s2e, fw, fe,
                                    input logic [2:0] t1, input logic r1, f1,
                                    input logic [2:0] t2, input logic r2, f2);
      exp_t e;
      logic [2:0] a, b;
      logic ra, fa, fb;
      if (ge && s1e) begin a = legal(t1); ra = r1; fa = f1; end
      else begin a = fe ? 3'd5 : 3'd0; ra = 1'b0; fa = 1'b0; end
      if (ge && s2e) begin
         b = legal(t2);
         e.t = fw ? b : ((a < b) ? a : b);
         e.ro = ra | r2;
         fb = f2;
      end else begin
         e.t = a; e.ro = ra; fb = 1'b0;
      end
      e.fs = fa ? 2'b01 : (fb ? 2'b10 : 2'b00);
      return e;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic send(input logic ge, s1e, s2e, fw, fe,
                       input logic [2:0] t1, input logic r1, f1,
                       input logic [2:0] t2, input logic r2, f2, input string req);
      @(negedge clk);
      in_valid = 1'b1; xlat_en = ge; s1_en = s1e; s2_en = s2e; fwb = fw; is_fetch = fe;
      s1_type = t1; s1_ro = r1; s1_fault = f1; s2_type = t2; s2_ro = r2; s2_fault = f2;
      exp_q.push_back(predict(ge, s1e, s2e, fw, fe, t1, r1, f1, t2, r2, f2));
      tag_q.push_back(req);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         s1_type = 3'd7; s2_type = 3'd3; s1_ro = ~s1_ro; s2_fault = ~s2_fault;
      end
   endtask

   // Monitor: sample two time units after each rising edge.
   always @(posedge clk) begin
      #2;
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check("R1 unexpected out_valid", 8'd1, 8'd0);
         end else begin
            exp_t e;
            string r;
            e = exp_q.pop_front();
            r = tag_q.pop_front();
            check({r, " type"}, {5'd0, eff_type}, {5'd0, e.t});
            check({r, " ro"}, {7'd0, eff_ro}, {7'd0, e.ro});
            check({r, " fault_stage"}, {6'd0, fault_stage}, {6'd0, e.fs});
         end
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [2:0] held_t;
      logic       held_ro;
      logic [1:0] held_fs;
      repeat (3) @(negedge clk);
      check("R2 reset out_valid", {7'd0, out_valid}, 8'd0);
      check("R2 reset type", {5'd0, eff_type}, 8'd0);
      check("R2 reset ro", {7'd0, eff_ro}, 8'd1);
      check("R2 reset fault_stage", {6'd0, fault_stage}, 8'd0);
      rst_n = 1'b1;
      idle(2);
      check("R2 post-reset hold type", {5'd0, eff_type}, 8'd0);
      check("R2 post-reset hold ro", {7'd0, eff_ro}, 8'd1);

      // R3 and R9: every code pair, both stages active, no override.
      for (int a = 0; a < 8; a++)
         for (int b = 0; b < 8; b++)
            send(1, 1, 1, 0, 0, 3'(a), 0, 0, 3'(b), 0, 0, "R3/R9 merge");
      // R4: override takes the stage-two code, including a less restrictive one.
      send(1, 1, 1, 1, 0, 3'd0, 0, 0, 3'd5, 0, 0, "R4 override up");
      send(1, 1, 1, 1, 0, 3'd5, 0, 0, 3'd2, 0, 0, "R4 override down");
      send(1, 1, 1, 1, 0, 3'd4, 0, 0, 3'd6, 0, 0, "R4/R9 override reserved");
      // R5: stage two off, its inputs are ignored.
      send(1, 1, 0, 1, 0, 3'd4, 0, 0, 3'd0, 1, 1, "R5 passthrough");
      send(1, 1, 0, 0, 0, 3'd5, 1, 0, 3'd1, 0, 1, "R5 passthrough ro");
      send(1, 1, 0, 0, 0, 3'd7, 0, 0, 3'd3, 0, 0, "R5/R9 reserved s1");
      // R6: stage one off or global off.
      send(1, 0, 0, 0, 0, 3'd5, 1, 1, 3'd5, 0, 0, "R6 data default");
      send(1, 0, 0, 0, 1, 3'd2, 1, 1, 3'd2, 0, 0, "R6 fetch default");
      send(0, 1, 1, 0, 1, 3'd0, 1, 1, 3'd0, 1, 1, "R6 global off fetch");
      send(0, 1, 1, 1, 0, 3'd5, 1, 1, 3'd4, 1, 1, "R6 global off data");
      send(1, 0, 1, 0, 1, 3'd0, 0, 1, 3'd3, 1, 0, "R6 s1 off s2 on");
      // R7: read-only from either stage.
      send(1, 1, 1, 0, 0, 3'd5, 1, 0, 3'd5, 0, 0, "R7 ro stage one");
      send(1, 1, 1, 0, 0, 3'd5, 0, 0, 3'd5, 1, 0, "R7 ro stage two");
      send(1, 1, 1, 1, 0, 3'd5, 1, 0, 3'd5, 1, 0, "R7 ro both");
      // R8: fault priority.
      send(1, 1, 1, 0, 0, 3'd5, 0, 1, 3'd5, 0, 1, "R8 both fault");
      send(1, 1, 1, 0, 0, 3'd5, 0, 0, 3'd5, 0, 1, "R8 stage two fault");
      send(1, 1, 1, 0, 0, 3'd5, 0, 1, 3'd5, 0, 0, "R8 stage one fault");
      send(1, 0, 1, 0, 0, 3'd5, 0, 1, 3'd5, 0, 1, "R8 s1 off fault ignored");
      send(1, 1, 0, 0, 0, 3'd5, 0, 0, 3'd5, 0, 1, "R8 s2 off fault ignored");
      idle(1);
      held_t = eff_type; held_ro = eff_ro; held_fs = fault_stage;
      idle(3);
      check("R1 idle out_valid", {7'd0, out_valid}, 8'd0);
      check("R1 hold type", {5'd0, eff_type}, {5'd0, held_t});
      check("R1 hold ro", {7'd0, eff_ro}, {7'd0, held_ro});
      check("R1 hold fault_stage", {6'd0, fault_stage}, {6'd0, held_fs});
      // R1: a single request gives a single result one cycle later.
      send(1, 1, 1, 0, 0, 3'd2, 0, 0, 3'd4, 0, 0, "R1 single");
      @(negedge clk);
      in_valid = 1'b0;
      check("R1 out_valid after one cycle", {7'd0, out_valid}, 8'd1);
      @(negedge clk);
      check("R1 out_valid drops", {7'd0, out_valid}, 8'd0);
      idle(2);
      check("R1 queue drained", 8'(exp_q.size()), 8'd0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule